// File: doc/BRIEF.md
# Two-Stage Nested Interrupt Controller

This block gathers fifteen interrupt request lines from two chained eight-input priority stages and drives one interrupt line toward a processor. The secondary stage resolves its own eight lines and presents its result as a level on line 2 of the primary stage, so the primary stage arbitrates seven direct lines plus the whole secondary group. Each stage holds a pending register, an in-service register and a mask register. Priority is fixed and fully nested: a level that is being serviced holds off itself and every level below it. A strictly higher level can still interrupt, so services nest.

The processor answers a raised interrupt with a one-cycle acknowledge strobe. In the next cycle the controller drops the interrupt and presents an 8-bit vector for one cycle. In the same cycle the granted request moves from pending to in-service. Software writes masks and end-of-interrupt commands through a small write port. An end-of-interrupt command is either non-specific, clearing the highest in-service level, or specific, clearing one named level.

The acknowledge handshake is a three-state machine. IDLE moves to RAISE when a request is eligible. RAISE moves to DONE on an acknowledge strobe while a request is still eligible, and back to IDLE if the eligible request vanishes. DONE always returns to IDLE. The interrupt output is high only in RAISE, and the vector is valid only in DONE.

Top module: `pic_cascade`

## Requirements
- R1: After reset every mask bit of both stages is 1 and every pending and in-service bit is 0. The interrupt output and the vector-valid output are 0, and a request that arrives while the masks still hold their reset value raises no interrupt.
- R2: A rising edge on an input line, seen through a two-flop synchronizer, sets that line's pending bit. The bit stays set, whatever the mask, until that line is acknowledged. `int_out` rises when an unmasked pending request is eligible under R5.
- R3: A mask bit of 1 makes its line invisible to arbitration. A write with `wr_addr`=0 loads the primary mask and `wr_addr`=1 loads the secondary mask, with bit n covering line n. Primary mask bit 2 hides the whole secondary group. The primary input `irq_pri[2]` is ignored because that line belongs to the cascade.
- R4: The fixed order, highest first, is primary 0, primary 1, secondary 0 to 7, then primary 3 to 7.
- R5: Within a stage, a request is eligible only if no in-service bit at its own or a higher level of that stage is set. While primary line 2 is in service, no secondary request reaches the processor. A strictly higher level still raises `int_out`.
- R6: An `inta` pulse while `int_out` is 1 makes `int_out` 0 in the next cycle. In that same cycle `vec_valid` is 1 for exactly one cycle. `vec_out` is 08h plus the line number for a primary line, or 70h plus the line number for a secondary line. An `inta` pulse while `int_out` is 0 has no effect.
- R7: On acknowledge, the granted line's pending bit clears and its in-service bit sets. Granting a secondary line sets both that secondary in-service bit and primary in-service bit 2.
- R8: Writing with `wr_data[7]`=0 to `wr_addr`=2 (primary) or 3 (secondary) is a non-specific end-of-interrupt. It clears that stage's highest-priority in-service bit that is set.
- R9: Writing with `wr_data[7]`=1 to `wr_addr`=2 or 3 is a specific end-of-interrupt. It clears only the in-service bit whose level is given in `wr_data[2:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_pri | input | 8 | Primary request lines (bit 2 unused) |
| irq_sec | input | 8 | Secondary request lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 primary mask, 1 secondary mask, 2 primary EOI, 3 secondary EOI |
| wr_data | input | 8 | Mask value, or EOI command (bit 7 specific, bits 2:0 level) |
| inta | input | 1 | Acknowledge strobe from the processor |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector strobe, one cycle after an accepted acknowledge |
| vec_out | output | 8 | Interrupt vector |

## Verification
Directed patterns raise three lines of different ranks at once, so that the order of the granted vectors separates the correct priority from a reversed or flat order. Nested sequences stack primary and secondary services. They tell a non-specific end-of-interrupt apart from a specific one by which held-off request is released. They also check that a secondary request stays blocked while primary line 2 is in service. Other patterns pulse the cascade input, mask lines and acknowledge with no interrupt raised, to confirm that these have no effect. A long random mix of pulses, masks, commands and acknowledges is compared step by step against a reference model written in bench functions.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RAISE = 2'd1,
        ST_DONE  = 2'd2
    } ack_state_t;

    localparam logic [1:0] ADDR_PRI_MASK = 2'd0;
    localparam logic [1:0] ADDR_SEC_MASK = 2'd1;
    localparam logic [1:0] ADDR_PRI_EOI  = 2'd2;
    localparam logic [1:0] ADDR_SEC_EOI  = 2'd3;
    localparam int         EOI_SPEC_BIT  = 7;

endpackage

// File: rtl/pic_resolve.sv
module pic_resolve #(
    parameter int LINES = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic [LINES-1:0] cand,
    input  logic [LINES-1:0] isr,
    output logic             hit,
    output logic [IDX_W-1:0] hit_lvl
);

    // Walk from the highest level (index 0) downward. An in-service bit
    // stops the walk, blocking its own level and every lower one.
    always_comb begin
        logic stop;
        hit     = 1'b0;
        hit_lvl = '0;
        stop    = 1'b0;
        for (int i = 0; i < LINES; i++) begin
            if (!stop) begin
                if (isr[i]) begin
                    stop = 1'b1;
                end else if (cand[i]) begin
                    hit     = 1'b1;
                    hit_lvl = IDX_W'(i);
                    stop    = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pic_stage.sv
module pic_stage #(
    parameter int               LINES       = 8,
    parameter int               SYNC_STAGES = 2,
    parameter logic [LINES-1:0] CASC_MASK   = '0,
    localparam int              IDX_W       = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] req_raw,
    input  logic             casc_req,
    input  logic             mask_we,
    input  logic [LINES-1:0] mask_d,
    input  logic             eoi_we,
    input  logic             eoi_spec,
    input  logic [IDX_W-1:0] eoi_lvl,
    input  logic             ack,
    input  logic [IDX_W-1:0] ack_lvl,
    output logic             pend_valid,
    output logic [IDX_W-1:0] pend_lvl
);

    logic [SYNC_STAGES-1:0][LINES-1:0] sync_q;
    logic [LINES-1:0] prev_q;
    logic [LINES-1:0] rise;
    logic [LINES-1:0] irr_q;
    logic [LINES-1:0] isr_q;
    logic [LINES-1:0] mask_q;
    logic [LINES-1:0] eff_req;
    logic [LINES-1:0] ack_vec;
    logic [LINES-1:0] eoi_vec;

    // Input synchronizer and rising-edge detect.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], req_raw};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Lines owned by the cascade never latch from their pins.
    assign rise    = sync_q[SYNC_STAGES-1] & ~prev_q & ~CASC_MASK;
    assign ack_vec = ack ? (LINES'(1) << ack_lvl) : '0;

    always_comb begin
        if (!eoi_we)
            eoi_vec = '0;
        else if (eoi_spec)
            eoi_vec = LINES'(1) << eoi_lvl;
        else
            eoi_vec = isr_q & (~isr_q + LINES'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irr_q  <= '0;
            isr_q  <= '0;
            mask_q <= '1;
        end else begin
            irr_q <= (irr_q & ~ack_vec) | rise;
            isr_q <= (isr_q & ~eoi_vec) | ack_vec;
            if (mask_we)
                mask_q <= mask_d;
        end
    end

    // The cascade line requests by level, straight from the lower stage.
    assign eff_req = (irr_q & ~CASC_MASK) | (casc_req ? CASC_MASK : '0);

    pic_resolve #(.LINES(LINES)) u_resolve (
        .cand    (eff_req & ~mask_q),
        .isr     (isr_q),
        .hit     (pend_valid),
        .hit_lvl (pend_lvl)
    );

    AST_MASK_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> !mask_q[pend_lvl]); // R3

    AST_NOT_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> !isr_q[pend_lvl]); // R5

    AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> isr_q[$past(ack_lvl)]); // R7

    AST_NONSPEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_we && !eoi_spec && !ack && (isr_q != '0)) |=>
        ($countones(isr_q) == $countones($past(isr_q)) - 1)); // R8

    AST_SPEC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_we && eoi_spec && !ack) |=> !isr_q[$past(eoi_lvl)]); // R9

endmodule

// File: rtl/pic_cascade.sv
module pic_cascade
    import pic_pkg::*;
#(
    parameter int         LINES        = 8,
    parameter int         CASCADE_LINE = 2,
    parameter int         SYNC_STAGES  = 2,
    parameter logic [7:0] PRI_BASE     = 8'h08,
    parameter logic [7:0] SEC_BASE     = 8'h70
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] irq_pri,
    input  logic [LINES-1:0] irq_sec,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             inta,
    output logic             int_out,
    output logic             vec_valid,
    output logic [7:0]       vec_out
);

    localparam int               IDX_W = $clog2(LINES);
    localparam logic [LINES-1:0] CASC  = LINES'(1) << CASCADE_LINE;

    ack_state_t       state_q, state_d;
    logic             p_valid, s_valid;
    logic [IDX_W-1:0] p_lvl, s_lvl;
    logic             p_ack, s_ack;
    logic [7:0]       vec_q, vec_d;
    logic             eoi_spec;
    logic [IDX_W-1:0] eoi_lvl;

    assign eoi_spec = wr_data[EOI_SPEC_BIT];
    assign eoi_lvl  = wr_data[IDX_W-1:0];

    assign p_ack = (state_q == ST_RAISE) && inta && p_valid;
    assign s_ack = p_ack && (p_lvl == IDX_W'(CASCADE_LINE));

    pic_stage #(
        .LINES(LINES), .SYNC_STAGES(SYNC_STAGES), .CASC_MASK('0)
    ) u_sec (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_raw    (irq_sec),
        .casc_req   (1'b0),
        .mask_we    (wr_en && wr_addr == ADDR_SEC_MASK),
        .mask_d     (wr_data[LINES-1:0]),
        .eoi_we     (wr_en && wr_addr == ADDR_SEC_EOI),
        .eoi_spec   (eoi_spec),
        .eoi_lvl    (eoi_lvl),
        .ack        (s_ack),
        .ack_lvl    (s_lvl),
        .pend_valid (s_valid),
        .pend_lvl   (s_lvl)
    );

    pic_stage #(
        .LINES(LINES), .SYNC_STAGES(SYNC_STAGES), .CASC_MASK(CASC)
    ) u_pri (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_raw    (irq_pri),
        .casc_req   (s_valid),
        .mask_we    (wr_en && wr_addr == ADDR_PRI_MASK),
        .mask_d     (wr_data[LINES-1:0]),
        .eoi_we     (wr_en && wr_addr == ADDR_PRI_EOI),
        .eoi_spec   (eoi_spec),
        .eoi_lvl    (eoi_lvl),
        .ack        (p_ack),
        .ack_lvl    (p_lvl),
        .pend_valid (p_valid),
        .pend_lvl   (p_lvl)
    );

    // Next-state logic of the acknowledge handshake.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (p_valid) state_d = ST_RAISE;
            ST_RAISE: if (!p_valid)   state_d = ST_IDLE;
                      else if (inta)  state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    assign vec_d = s_ack ? (SEC_BASE + 8'(s_lvl)) : (PRI_BASE + 8'(p_lvl));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            vec_q <= '0;
        else if (p_ack)
            vec_q <= vec_d;
    end

    always_comb begin
        int_out   = (state_q == ST_RAISE);
        vec_valid = (state_q == ST_DONE);
        vec_out   = vec_q;
    end

    AST_INT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (int_out && inta) |=> (!int_out && vec_valid)); // R6

    AST_VEC_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(int_out && inta)); // R6

    AST_VEC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid); // R6

    AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (((vec_out - PRI_BASE) < 8'(LINES) &&
                        (vec_out - PRI_BASE) != 8'(CASCADE_LINE)) ||
                       ((vec_out - SEC_BASE) < 8'(LINES)))); // R6

endmodule

// File: tb/pic_cascade_test.sv
`timescale 1ns/1ps
module pic_cascade_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_pri = '0;
    logic [7:0] irq_sec = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       inta = 1'b0;
    logic       int_out, vec_valid;
    logic [7:0] vec_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Reference state
    logic [7:0] m_pirr = '0, m_pisr = '0, m_pmask = '1;
    logic [7:0] m_sirr = '0, m_sisr = '0, m_smask = '1;

    always #2 clk = ~clk;

    pic_cascade uut (
        .clk(clk), .rst_n(rst_n), .irq_pri(irq_pri), .irq_sec(irq_sec),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .inta(inta),
        .int_out(int_out), .vec_valid(vec_valid), .vec_out(vec_out)
    );

    // {found, level}: walk from level 0, stop at in-service or candidate.
    function automatic logic [3:0] pick(input logic [7:0] cand, input logic [7:0] isr);
        for (int i = 0; i < 8; i++) begin
            if (isr[i]) return 4'b0000;
            if (cand[i]) return {1'b1, 3'(i)};
        end
        return 4'b0000;
    endfunction

    function automatic logic [3:0] sec_pick();
        return pick(m_sirr & ~m_smask, m_sisr);
    endfunction

    function automatic logic [3:0] pri_pick();
        logic [3:0] s = sec_pick();
        logic [7:0] req = (m_pirr & ~8'h04) | (s[3] ? 8'h04 : 8'h00);
        return pick(req & ~m_pmask, m_pisr);
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_int(input string tag);
        logic [3:0] p = pri_pick();
        check(tag, {7'd0, int_out}, {7'd0, p[3]});
    endtask

    task automatic pulse(input bit sec, input int line);
        if (sec) irq_sec[line] = 1'b1; else irq_pri[line] = 1'b1;
        cyc(3);
        if (sec) irq_sec[line] = 1'b0; else irq_pri[line] = 1'b0;
        cyc(3);
        if (sec) m_sirr[line] = 1'b1;
        else if (line != 2) m_pirr[line] = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc(1);
        wr_en = 1'b0;
        cyc(2);
        case (a)
            2'd0: m_pmask = d;
            2'd1: m_smask = d;
            default: begin
                logic [7:0] isr = (a == 2'd2) ? m_pisr : m_sisr;
                if (d[7]) isr[d[2:0]] = 1'b0;
                else isr = isr & (~isr + 8'd1);
                isr = (d[7]) ? isr : (((a == 2'd2) ? m_pisr : m_sisr) & ~isr);
                if (a == 2'd2) m_pisr = isr; else m_sisr = isr;
            end
        endcase
    endtask

    task automatic ack(input string tag);
        logic [3:0] p = pri_pick();
        logic [3:0] s = sec_pick();
        logic [7:0] ev;
        check({tag, " int before ack"}, {7'd0, int_out}, {7'd0, p[3]});
        inta = 1'b1;
        cyc(1);
        inta = 1'b0;
        if (p[3]) begin
            if (p[2:0] == 3'd2) begin
                ev = 8'h70 + {5'd0, s[2:0]};
                m_sisr[s[2:0]] = 1'b1; m_sirr[s[2:0]] = 1'b0; m_pisr[2] = 1'b1;
            end else begin
                ev = 8'h08 + {5'd0, p[2:0]};
                m_pisr[p[2:0]] = 1'b1; m_pirr[p[2:0]] = 1'b0;
            end
            check({tag, " R6 int drop"}, {7'd0, int_out}, 8'd0);
            check({tag, " R6 vec_valid"}, {7'd0, vec_valid}, 8'd1);
            check({tag, " R6 vector"}, vec_out, ev);
        end else begin
            check({tag, " R6 ignored ack"}, {7'd0, vec_valid}, 8'd0);
        end
        cyc(1);
        check({tag, " R6 single strobe"}, {7'd0, vec_valid}, 8'd0);
        cyc(2);
    endtask

    task automatic ack_expect(input string tag, input logic [7:0] ev);
        logic [3:0] p = pri_pick();
        logic [3:0] s = sec_pick();
        logic [7:0] mv = (p[2:0] == 3'd2) ? 8'h70 + {5'd0, s[2:0]} : 8'h08 + {5'd0, p[2:0]};
        check({tag, " expected order"}, mv, ev);
        ack(tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        // R1: reset state
        check("R1 int_out after reset", {7'd0, int_out}, 8'd0);
        check("R1 vec_valid after reset", {7'd0, vec_valid}, 8'd0);
        pulse(1'b0, 0);
        check_int("R1 masked by reset value");
        // R2: pending survives while masked, raises when unmasked
        wr(2'd0, 8'h00);
        check_int("R2 pending raised after unmask");
        check("R2 int high", {7'd0, int_out}, 8'd1);
        ack_expect("R7 primary 0", 8'h08);
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h00);
        check_int("R8 idle after eoi");
        // R3: cascade pin ignored
        pulse(1'b0, 2);
        check("R3 irq_pri[2] ignored", {7'd0, int_out}, 8'd0);
        // R3: masked line ignored, then released
        wr(2'd0, 8'h40);
        pulse(1'b0, 6);
        check("R3 masked line", {7'd0, int_out}, 8'd0);
        wr(2'd0, 8'h00);
        check("R3 unmasked line", {7'd0, int_out}, 8'd1);
        ack_expect("R3 line 6", 8'h0E);
        wr(2'd2, 8'h00);
        // R3: primary bit 2 hides secondary group
        wr(2'd0, 8'h04);
        pulse(1'b1, 5);
        check("R3 secondary hidden", {7'd0, int_out}, 8'd0);
        wr(2'd0, 8'h00);
        ack_expect("R7 secondary 5", 8'h75);
        wr(2'd3, 8'h00);
        wr(2'd2, 8'h00);
        // R6: ack with no interrupt
        ack("R6 stray ack");
        // R4: three ranks at once
        pulse(1'b0, 4); pulse(1'b1, 3); pulse(1'b0, 1);
        ack_expect("R4 first p1", 8'h09);
        check("R5 lower held off", {7'd0, int_out}, 8'd0);
        wr(2'd2, 8'h00);
        ack_expect("R4 second s3", 8'h73);
        wr(2'd3, 8'h00);
        wr(2'd2, 8'h00);
        ack_expect("R4 third p4", 8'h0C);
        wr(2'd2, 8'h00);
        // R5 nesting, R8 vs R9
        pulse(1'b0, 5);
        ack_expect("R5 base p5", 8'h0D);
        pulse(1'b0, 3);
        check("R5 higher nests", {7'd0, int_out}, 8'd1);
        ack_expect("R5 nested p3", 8'h0B);
        pulse(1'b1, 0);
        check("R5 secondary above p3", {7'd0, int_out}, 8'd1);
        ack_expect("R5 nested s0", 8'h70);
        pulse(1'b0, 4);
        check("R5 p4 blocked", {7'd0, int_out}, 8'd0);
        wr(2'd2, 8'h85);
        check("R9 specific clears only p5", {7'd0, int_out}, 8'd0);
        wr(2'd2, 8'h00);
        check("R8 non-specific cleared p2 only", {7'd0, int_out}, 8'd0);
        pulse(1'b1, 1);
        check("R5 secondary blocked by own isr", {7'd0, int_out}, 8'd0);
        wr(2'd3, 8'h00);
        check("R8 release s1", {7'd0, int_out}, 8'd1);
        ack_expect("R8 nested s1", 8'h71);
        wr(2'd3, 8'h81);
        wr(2'd2, 8'h82);
        check("R9 specific releases nothing above p3", {7'd0, int_out}, 8'd0);
        wr(2'd2, 8'h83);
        ack_expect("R9 p4 after release", 8'h0C);
        wr(2'd2, 8'h84);
        check_int("R9 all clear");
        // Random mix against the model
        for (int it = 0; it < 600; it++) begin
            int r = $urandom_range(0, 11);
            if (r <= 4) pulse($urandom_range(0, 1) == 1, $urandom_range(0, 7));
            else if (r <= 7) ack("R6 R7 random ack");
            else if (r <= 9) wr(2'($urandom_range(2, 3)),
                               {1'($urandom_range(0, 1)), 4'd0, 3'($urandom_range(0, 7))});
            else wr(2'($urandom_range(0, 1)), 8'($urandom & $urandom & $urandom));
            check_int("R2 R4 R5 random int level");
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule